// File: doc/BRIEF.md
# Programmable Interval Counter Channel

A single binary down-counting timer channel of the kind found in a multi-channel interval timer. It advances only on cycles where the clock-enable tick is high. Each counting period is a count value captured from a load strobe. A 3-bit operating mode is captured with the count, and the mode decides the output waveform. The choices are a terminal-count flag, a gate-retriggered one-shot, a periodic rate pulse, a square wave, and two single-tick strobes: one started by the load, one started again by the gate.

A register front end outside this block writes the count and mode through the load port and reads `curCount` at any time. The gate input either restarts the current period on a rising edge or has no effect, depending on the mode. A loaded value of zero stands for the full period of 2^CNT_W ticks.

Top module: `interval_timer_channel`

## Requirements
- R1: On a cycle with `loadStb` high, the count and mode are captured and elapsed time restarts at zero. On the next cycle `curCount` equals the loaded value. A load takes priority over a tick and over a gate edge in the same cycle.
- R2: A loaded count of 0 acts as a period of 65536 ticks (2^CNT_W). In mode 0 the output rises only after 65536 ticks, and `curCount` reads 0 directly after the load.
- R3: Mode codes 6 and 7 behave exactly like modes 2 and 3.
- R4: Mode 0: `chanOut` is low after a load and goes high once the elapsed ticks reach the count. It then stays high until the next load.
- R5: Mode 1: `chanOut` is low while the elapsed ticks are below the count and high after that. A gate rising edge restarts the count and drives the output low again.
- R6: Mode 2: `chanOut` is high for exactly the tick interval where the elapsed ticks are a nonzero multiple of the count. It is low otherwise, including directly after a load.
- R7: Mode 3: with p = elapsed ticks modulo the count N, `chanOut` is high while p < (N+1)/2 and low otherwise. `curCount` reads N - (2p mod N), taken to 16 bits.
- R8: Modes 4 and 5: `chanOut` is high only during the single tick interval where the elapsed ticks equal the count. There is no further pulse until the channel is loaded again.
- R9: A gate rising edge (gate high now and low on the previous clock) resets elapsed time to zero in modes 1, 2, 3 and 5. In modes 0 and 4 the edge has no effect, and counting continues.
- R10: In modes 0, 1, 4 and 5, `curCount` is the loaded count minus the elapsed ticks, modulo 65536. In mode 2 it is N minus (elapsed ticks modulo N), modulo 65536.
- R11: On a clock without `tickEn`, without a load and without a retriggering gate edge, `curCount` and `chanOut` hold their values.
- R12: A synchronous reset leaves the channel in mode 0 with a zero (65536) count. After reset `chanOut` is low and `curCount` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tickEn | input | 1 | Count enable; one tick per high cycle |
| loadStb | input | 1 | Captures loadCount and loadMode |
| loadCount | input | CNT_W | Initial count, 0 meaning 2^CNT_W |
| loadMode | input | 3 | Operating mode code 0..7 |
| gate | input | 1 | Gate; rising edge retriggers modes 1, 2, 3, 5 |
| chanOut | output | 1 | Mode-dependent output waveform |
| curCount | output | CNT_W | Live readable count |

## Verification
The assertions assume that a load strobe is never raised while reset is active, and that no property needs history from before the first clock after reset. The hold and single-pulse properties count on the gate edge being detected one clock after gate is sampled. The bench drives every input at the falling clock edge, keeps reset apart from loads, and holds gate steady during the mode sweeps. It toggles gate only in the retrigger runs, where the reference model applies the same edge rule.

// File: rtl/itc_pkg.sv
package itc_pkg;

  // Operating modes after folding codes 6 and 7 onto 2 and 3.
  typedef enum logic [2:0] {
    MODE_TC_FLAG   = 3'd0,
    MODE_ONESHOT   = 3'd1,
    MODE_RATE      = 3'd2,
    MODE_SQUARE    = 3'd3,
    MODE_SW_STROBE = 3'd4,
    MODE_HW_STROBE = 3'd5
  } chan_mode_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;      // capture new count, restart period
    logic restart;   // gate-triggered restart
    logic step;      // advance elapsed ticks by one
    logic periodic;  // elapsed wraps at the count (modes 2 and 3)
  } chan_ctrl_t;

  function automatic chan_mode_e foldMode(input logic [2:0] raw);
    if (raw[2:1] == 2'b11) return chan_mode_e'({1'b0, raw[1:0]});
    return chan_mode_e'(raw);
  endfunction

  function automatic logic retriggers(input chan_mode_e m);
    return (m == MODE_ONESHOT) || (m == MODE_RATE) ||
           (m == MODE_SQUARE)  || (m == MODE_HW_STROBE);
  endfunction

endpackage

// File: rtl/itc_ctrl.sv
module itc_ctrl
  import itc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tickEn,
  input  logic       loadStb,
  input  logic [2:0] loadMode,
  input  logic       gate,
  output chan_ctrl_t strobes,
  output chan_mode_e modeQ,
  output logic       gateRise
);

  logic gatePrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ    <= MODE_TC_FLAG;
      gatePrev <= gate;
    end else begin
      gatePrev <= gate;
      if (loadStb) modeQ <= foldMode(loadMode);
    end
  end

  assign gateRise = gate && !gatePrev;

  always_comb begin
    strobes.load     = loadStb;
    strobes.restart  = !loadStb && gateRise && retriggers(modeQ);
    strobes.step     = !loadStb && !strobes.restart && tickEn;
    strobes.periodic = (modeQ == MODE_RATE) || (modeQ == MODE_SQUARE);
  end

endmodule

// File: rtl/itc_datapath.sv
module itc_datapath
  import itc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  chan_ctrl_t       strobes,
  input  logic [CNT_W-1:0] loadCount,
  output logic [CNT_W:0]   cntN,
  output logic [CNT_W-1:0] phase,
  output logic             doneQ,
  output logic             pulseQ
);

  localparam int NW = CNT_W + 1;

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] phaseQ;
  logic [NW-1:0]    phaseNext;
  logic             reachEnd;

  // Stored zero stands for the full 2^CNT_W period.
  assign cntN      = {(cntQ == '0), cntQ};
  assign phaseNext = {1'b0, phaseQ} + NW'(1);
  assign reachEnd  = (phaseNext == cntN);
  assign phase     = phaseQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      cntQ   <= '0;
      phaseQ <= '0;
      doneQ  <= 1'b0;
      pulseQ <= 1'b0;
    end else if (strobes.load) begin
      cntQ   <= loadCount;
      phaseQ <= '0;
      doneQ  <= 1'b0;
      pulseQ <= 1'b0;
    end else if (strobes.restart) begin
      phaseQ <= '0;
      doneQ  <= 1'b0;
      pulseQ <= 1'b0;
    end else if (strobes.step) begin
      if (strobes.periodic) begin
        phaseQ <= reachEnd ? '0 : phaseNext[CNT_W-1:0];
        pulseQ <= reachEnd;
      end else begin
        phaseQ <= phaseNext[CNT_W-1:0];
        pulseQ <= reachEnd && !doneQ;
        if (reachEnd) doneQ <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/itc_out_decode.sv
module itc_out_decode
  import itc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  chan_mode_e       modeQ,
  input  logic [CNT_W:0]   cntN,
  input  logic [CNT_W-1:0] phase,
  input  logic             doneQ,
  input  logic             pulseQ,
  output logic             chanOut,
  output logic [CNT_W-1:0] curCount
);

  localparam int NW = CNT_W + 1;

  logic [NW-1:0] halfN;
  logic [NW-1:0] dbl;
  logic [NW-1:0] dblMod;
  logic [NW-1:0] sqRemain;

  always_comb begin
    halfN    = (cntN + NW'(1)) >> 1;
    dbl      = {phase, 1'b0};
    dblMod   = (dbl >= cntN) ? dbl - cntN : dbl;
    sqRemain = cntN - dblMod;

    unique case (modeQ)
      MODE_TC_FLAG, MODE_ONESHOT:               chanOut = doneQ;
      MODE_RATE, MODE_SW_STROBE, MODE_HW_STROBE: chanOut = pulseQ;
      MODE_SQUARE:                              chanOut = ({1'b0, phase} < halfN);
      default:                                  chanOut = 1'b0;
    endcase

    if (modeQ == MODE_SQUARE) curCount = sqRemain[CNT_W-1:0];
    else                      curCount = cntN[CNT_W-1:0] - phase;
  end

endmodule

// File: rtl/interval_timer_channel.sv
module interval_timer_channel
  import itc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tickEn,
  input  logic             loadStb,
  input  logic [CNT_W-1:0] loadCount,
  input  logic [2:0]       loadMode,
  input  logic             gate,
  output logic             chanOut,
  output logic [CNT_W-1:0] curCount
);

  chan_ctrl_t       strobes;
  chan_mode_e       modeQ;
  logic             gateRise;
  logic [CNT_W:0]   cntN;
  logic [CNT_W-1:0] phase;
  logic             doneQ;
  logic             pulseQ;
  logic [2:0]       modeCur;

  assign modeCur = modeQ;

  itc_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .tickEn   (tickEn),
    .loadStb  (loadStb),
    .loadMode (loadMode),
    .gate     (gate),
    .strobes  (strobes),
    .modeQ    (modeQ),
    .gateRise (gateRise)
  );

  itc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .loadCount (loadCount),
    .cntN      (cntN),
    .phase     (phase),
    .doneQ     (doneQ),
    .pulseQ    (pulseQ)
  );

  itc_out_decode #(.CNT_W(CNT_W)) u_out (
    .modeQ    (modeQ),
    .cntN     (cntN),
    .phase    (phase),
    .doneQ    (doneQ),
    .pulseQ   (pulseQ),
    .chanOut  (chanOut),
    .curCount (curCount)
  );

endmodule

// File: rtl/interval_timer_channel_chk.sv
module interval_timer_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tickEn,
  input logic             loadStb,
  input logic [CNT_W-1:0] loadCount,
  input logic             gateRise,
  input logic [2:0]       modeCur,
  input logic             chanOut,
  input logic [CNT_W-1:0] curCount
);

  assert_load_readback_R1: assert property (@(posedge clk) disable iff (rst)
    loadStb |=> (curCount == $past(loadCount)));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!tickEn && !loadStb && !gateRise) |=> ($stable(curCount) && $stable(chanOut)));

  assert_tc_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (modeCur == 3'd0 && chanOut && !loadStb) |=> chanOut);

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (rst)
    ((modeCur == 3'd4 || modeCur == 3'd5) && chanOut && tickEn && !loadStb && !gateRise)
      |=> !chanOut);

  assert_gate_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    ((modeCur == 3'd0 || modeCur == 3'd4) && !tickEn && !loadStb) |=> $stable(curCount));

  assert_oneshot_retrig_R5: assert property (@(posedge clk) disable iff (rst)
    (modeCur == 3'd1 && gateRise && !loadStb) |=> !chanOut);

endmodule

bind interval_timer_channel interval_timer_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tickEn    (tickEn),
  .loadStb   (loadStb),
  .loadCount (loadCount),
  .gateRise  (gateRise),
  .modeCur   (modeCur),
  .chanOut   (chanOut),
  .curCount  (curCount)
);

// File: tb/tb_interval_timer_channel.sv
`timescale 1ns/1ps
module tb_interval_timer_channel;

  localparam int W    = 16;
  localparam int FULL = 1 << W;
  localparam int MASK = FULL - 1;

  logic         clk = 1'b0;
  logic         rst, tickEn, loadStb, gate;
  logic [W-1:0] loadCount;
  logic [2:0]   loadMode;
  logic         chanOut;
  logic [W-1:0] curCount;

  always #10 clk = ~clk;

  interval_timer_channel #(.CNT_W(W)) dut (
    .clk(clk), .rst(rst), .tickEn(tickEn), .loadStb(loadStb),
    .loadCount(loadCount), .loadMode(loadMode), .gate(gate),
    .chanOut(chanOut), .curCount(curCount)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // Reference model state
  int mN, mMode, mD;
  bit mGatePrev;

  function automatic int expOut();
    int r = mD % mN;
    case (mMode)
      0, 1:    return (mD >= mN) ? 1 : 0;
      2:       return (r == 0 && mD != 0) ? 1 : 0;
      3:       return (r < (mN + 1) / 2) ? 1 : 0;
      default: return (mD == mN) ? 1 : 0;
    endcase
  endfunction

  function automatic int expCnt();
    int r = mD % mN;
    case (mMode)
      2:       return (mN - r) & MASK;
      3:       return (mN - ((2 * r) % mN)) & MASK;
      default: return (mN - mD) & MASK;
    endcase
  endfunction

  function automatic string outTag(input int rawMode);
    if (rawMode >= 6) return "R3";
    case (rawMode)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic checkOut(input string tag);
    total++;
    if (int'(chanOut) != expOut()) begin
      bad++;
      $display("FAIL %s chanOut act=%0d exp=%0d (mode=%0d N=%0d d=%0d)",
               tag, chanOut, expOut(), mMode, mN, mD);
    end
  endtask

  task automatic checkCnt(input string tag);
    total++;
    if (int'(curCount) != expCnt()) begin
      bad++;
      $display("FAIL %s curCount act=%0d exp=%0d (mode=%0d N=%0d d=%0d)",
               tag, curCount, expCnt(), mMode, mN, mD);
    end
  endtask

  task automatic cyc(input bit ld, input int cnt, input int md, input bit tk, input bit g);
    bit rise;
    @(negedge clk);
    loadStb = ld; loadCount = cnt[W-1:0]; loadMode = md[2:0]; tickEn = tk; gate = g;
    @(posedge clk);
    rise = g && !mGatePrev;
    mGatePrev = g;
    if (ld) begin
      mN    = (cnt[W-1:0] == 0) ? FULL : int'(cnt[W-1:0]);
      mMode = (md >= 6) ? md - 4 : md;
      mD    = 0;
    end else if (rise && (mMode == 1 || mMode == 2 || mMode == 3 || mMode == 5)) begin
      mD = 0;
    end else if (tk) begin
      mD++;
    end
    #5;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1; tickEn = 0; loadStb = 0; gate = 1; loadCount = '0; loadMode = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    mN = FULL; mMode = 0; mD = 0; mGatePrev = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    doReset();
    // R12: reset state
    checkOut("R12");
    checkCnt("R12");

    // Mode sweep over every code and small counts; load coincides with a tick (R1)
    for (int md = 0; md < 8; md++) begin
      for (int n = 1; n <= 6; n++) begin
        cyc(1, n, md, 1, 1);
        checkCnt("R1");
        checkOut(outTag(md));
        for (int k = 0; k < 3 * n + 4; k++) begin
          bit tk = (k % 4) != 3;
          cyc(0, 0, 0, tk, 1);
          checkOut(tk ? outTag(md) : "R11");
          checkCnt(tk ? ((md == 3 || md == 7) ? "R7" : "R10") : "R11");
        end
      end
    end

    // Gate retrigger behaviour per mode
    for (int md = 0; md < 6; md++) begin
      cyc(1, 4, md, 0, 0);
      for (int k = 0; k < 5; k++) cyc(0, 0, 0, 1, 0);
      checkOut("R9");
      checkCnt("R9");
      cyc(0, 0, 0, 1, 1);
      checkOut("R9");
      checkCnt("R9");
      for (int k = 0; k < 6; k++) begin
        cyc(0, 0, 0, (k % 3) != 2, 1);
        checkOut(md == 1 ? "R5" : "R9");
        checkCnt("R9");
      end
    end

    // Load wins over a simultaneous gate edge
    cyc(1, 3, 1, 0, 0);
    cyc(0, 0, 0, 1, 0);
    cyc(1, 9, 1, 1, 1);
    checkCnt("R1");
    checkOut("R1");

    // Zero count means 65536 ticks (R2)
    cyc(1, 0, 0, 0, 1);
    checkCnt("R2");
    checkOut("R2");
    for (int k = 0; k < FULL - 1; k++) cyc(0, 0, 0, 1, 1);
    checkOut("R2");
    checkCnt("R2");
    cyc(0, 0, 0, 1, 1);
    checkOut("R2");
    checkCnt("R2");
    cyc(0, 0, 0, 1, 1);
    checkOut("R4");
    checkCnt("R10");

    cyc(1, 0, 3, 0, 1);
    checkOut("R2");
    checkCnt("R2");
    cyc(0, 0, 0, 1, 1);
    checkCnt("R2");
    checkOut("R7");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule